// File: doc/BRIEF.md
# 3xN Convolution Engine

This engine slides a kernel three rows tall and N columns wide across a strip of three image rows and stores one result per column position. The number of columns N, the strip width W, the number of kernels and a pooling switch arrive as configuration inputs. They are captured on the start pulse, so the surrounding logic may change them once a run has begun. The engine reads the image and kernel memories through synchronous-read ports. Each run produces W-N+1 outputs per kernel, and kernels are processed one after another.

Each output comes from a signed multiply-accumulate over the 3xN window and is clamped to 16 bits. The output then passes to a stage that either forwards it unchanged or keeps only the larger of each consecutive pair. Results are written in order to the result memory, and a done flag follows the last write.

The controller has five states:
- IDLE: the state after reset.
- RUN: addresses are issued.
- DRAIN: the pipeline empties.
- FLUSH: the last write is in flight.
- DONE: done is high.

The transitions are:
- IDLE or DONE goes to RUN on an accepted start.
- RUN goes to DRAIN once the final address is issued.
- DRAIN goes to FLUSH when the final convolution result leaves the datapath.
- FLUSH always goes to DONE.

A start pulse in RUN, DRAIN or FLUSH is ignored. The configuration must satisfy 1 <= N <= W and at least one kernel.

Top module: `conv3n_engine`

## Requirements
- R1: After reset the engine is idle: done is 0, no read enables are raised and no result is written until a start pulse arrives.
- R2: The image word for row r (0..2) and column c sits at address r*W + c. The kernel word for kernel k, row r and column j sits at address k*3*N + r*N + j. Window i covers image columns i to i+N-1.
- R3: Each convolution result is the signed sum of pixel*weight over the 3xN window, with 8-bit signed operands, clamped to the range -32768..32767.
- R4: With pooling on (cfg_pool=1), the engine writes max(result 2m, result 2m+1) for each pair m inside a kernel's results, comparing as signed values.
- R5: With pooling on and an odd count W-N+1, the last result of each kernel is discarded and never paired with the next kernel's first result.
- R6: With pooling off, every one of the W-N+1 results of each kernel is written unchanged.
- R7: Let P be W-N+1 with pooling off and floor((W-N+1)/2) with pooling on. Kernel k's outputs occupy addresses k*P .. k*P+P-1 in ascending order, and no other writes occur.
- R8: done rises only after the last result write has completed. It then stays high until the next start pulse and falls in the cycle after that pulse is taken.
- R9: A start pulse arriving while a run is in progress has no effect on the run or its results.
- R10: Configuration is sampled when start is taken. Changes on the configuration inputs during a run do not alter its results.
- R11: The 20-bit accumulator never wraps for any N up to the maximum column count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request |
| cfg_width | input | 6 | Image strip width W |
| cfg_ncols | input | 4 | Kernel width N |
| cfg_nkern | input | 3 | Number of kernels |
| cfg_pool | input | 1 | 1 enables pairwise max pooling |
| img_rd_en | output | 1 | Image memory read enable |
| img_addr | output | 7 | Image memory read address |
| img_rdata | input | 8 | Image word, one cycle after its address |
| ker_rd_en | output | 1 | Kernel memory read enable |
| ker_addr | output | 7 | Kernel memory read address |
| ker_rdata | input | 8 | Kernel word, one cycle after its address |
| res_we | output | 1 | Result memory write strobe |
| res_addr | output | 7 | Result memory write address |
| res_wdata | output | 16 | Result word, signed |
| done | output | 1 | Run complete |

## Verification
The bench targets several corner cases:
- Odd result counts under pooling. A design that carried the unpaired result across a kernel boundary would shift every later address and value.
- A single-output configuration with pooling on, where no writes may occur but done must still rise.
- Kernels as wide as the strip and one column wide. A wrong window-end compare would run past the strip or stop early.
- Operands chosen to drive the sum past both 16-bit limits, which catches a clamp that wraps instead.
- A start pulse and configuration changes injected mid-run. An engine that re-armed or re-read its inputs would emit a different write stream.
- The instant done rises, compared against the write queue, which catches a flag that runs ahead of the last store.

// File: rtl/ce_pkg.sv
package ce_pkg;
    parameter int PIX_W = 8;
    parameter int ACC_W = 20;
    parameter int OUT_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_DRAIN = 3'd2,
        ST_FLUSH = 3'd3,
        ST_DONE  = 3'd4
    } ce_state_t;

    // Clamp a wide accumulator value into the output range.
    function automatic logic signed [OUT_W-1:0] ce_saturate(input logic signed [ACC_W-1:0] a);
        logic fits;
        fits = (&a[ACC_W-1:OUT_W-1]) | ~(|a[ACC_W-1:OUT_W-1]);
        if (fits)
            return a[OUT_W-1:0];
        else if (a[ACC_W-1])
            return {1'b1, {(OUT_W-1){1'b0}}};
        else
            return {1'b0, {(OUT_W-1){1'b1}}};
    endfunction
endpackage

// File: rtl/ce_agu.sv
module ce_agu #(
    parameter int MAX_W = 32,
    parameter int MAX_N = 8,
    parameter int MAX_K = 4,
    localparam int W_W    = $clog2(MAX_W + 1),
    localparam int N_W    = $clog2(MAX_N + 1),
    localparam int K_W    = $clog2(MAX_K + 1),
    localparam int IMG_AW = $clog2(3 * MAX_W),
    localparam int KER_AW = $clog2(3 * MAX_N * MAX_K)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [W_W-1:0]    w_q,
    input  logic [N_W-1:0]    n_q,
    input  logic [K_W-1:0]    k_q,
    output logic [IMG_AW-1:0] img_addr,
    output logic [KER_AW-1:0] ker_addr,
    output logic              iss_first,
    output logic              iss_last,
    output logic              iss_klast,
    output logic              iss_final
);
    logic [1:0]     row;
    logic [N_W-1:0] col;
    logic [W_W-1:0] pos;
    logic [K_W-1:0] kern;

    logic col_end, row_end, pos_end, kern_end;

    always_comb begin
        col_end  = (col == n_q - N_W'(1));
        row_end  = (row == 2'd2);
        pos_end  = (pos == w_q - W_W'(n_q));
        kern_end = (kern == k_q - K_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row  <= '0;
            col  <= '0;
            pos  <= '0;
            kern <= '0;
        end else if (clear) begin
            row  <= '0;
            col  <= '0;
            pos  <= '0;
            kern <= '0;
        end else if (run) begin
            if (!col_end) begin
                col <= col + N_W'(1);
            end else begin
                col <= '0;
                if (!row_end) begin
                    row <= row + 2'd1;
                end else begin
                    row <= '0;
                    if (!pos_end) begin
                        pos <= pos + W_W'(1);
                    end else begin
                        pos  <= '0;
                        kern <= kern_end ? '0 : kern + K_W'(1);
                    end
                end
            end
        end
    end

    always_comb begin
        img_addr  = IMG_AW'(row) * IMG_AW'(w_q) + IMG_AW'(pos) + IMG_AW'(col);
        ker_addr  = KER_AW'(kern) * KER_AW'(3) * KER_AW'(n_q)
                  + KER_AW'(row) * KER_AW'(n_q) + KER_AW'(col);
        iss_first = (row == 2'd0) && (col == '0);
        iss_last  = col_end && row_end;
        iss_klast = iss_last && pos_end;
        iss_final = iss_klast && kern_end;
    end

    // R2: reads stay inside the three-row strip and the kernel set
    assert_img_in_strip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (32'(img_addr) < 3 * 32'(w_q)));
    assert_ker_in_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (32'(ker_addr) < 3 * 32'(n_q) * 32'(k_q)));
endmodule

// File: rtl/ce_mac.sv
module ce_mac
    import ce_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_vld,
    input  logic                    iss_first,
    input  logic                    iss_last,
    input  logic                    iss_klast,
    input  logic                    iss_final,
    input  logic signed [PIX_W-1:0] pix,
    input  logic signed [PIX_W-1:0] wt,
    output logic                    conv_vld,
    output logic signed [OUT_W-1:0] conv_val,
    output logic                    conv_klast,
    output logic                    conv_final
);
    // Tags that travel with the read data through the memory latency.
    logic rd_vld, rd_first, rd_last, rd_klast, rd_final;
    logic signed [ACC_W-1:0]     acc;
    logic signed [2*PIX_W-1:0]   prod;
    logic signed [ACC_W-1:0]     prod_ext;
    logic signed [ACC_W-1:0]     acc_base;
    logic signed [ACC_W-1:0]     acc_next;

    always_comb begin
        prod     = pix * wt;
        prod_ext = {{(ACC_W-2*PIX_W){prod[2*PIX_W-1]}}, prod};
        acc_base = rd_first ? '0 : acc;
        acc_next = acc_base + prod_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld     <= 1'b0;
            rd_first   <= 1'b0;
            rd_last    <= 1'b0;
            rd_klast   <= 1'b0;
            rd_final   <= 1'b0;
            acc        <= '0;
            conv_vld   <= 1'b0;
            conv_val   <= '0;
            conv_klast <= 1'b0;
            conv_final <= 1'b0;
        end else begin
            rd_vld   <= iss_vld;
            rd_first <= iss_first;
            rd_last  <= iss_last;
            rd_klast <= iss_klast;
            rd_final <= iss_final;
            conv_vld <= rd_vld && rd_last;
            if (rd_vld)
                acc <= acc_next;
            if (rd_vld && rd_last) begin
                conv_val   <= ce_saturate(acc_next);
                conv_klast <= rd_klast;
                conv_final <= rd_final;
            end
        end
    end

    // R11: adding a product of the same sign never flips the running sum's sign
    assert_acc_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && (acc_base[ACC_W-1] == prod_ext[ACC_W-1]))
        |-> (acc_next[ACC_W-1] == acc_base[ACC_W-1]));
endmodule

// File: rtl/ce_pool.sv
module ce_pool
    import ce_pkg::*;
#(
    parameter int RES_AW = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    pool_en,
    input  logic                    conv_vld,
    input  logic signed [OUT_W-1:0] conv_val,
    input  logic                    conv_klast,
    output logic                    res_we,
    output logic [RES_AW-1:0]       res_addr,
    output logic signed [OUT_W-1:0] res_wdata
);
    logic                    phase;
    logic signed [OUT_W-1:0] hold;
    logic [RES_AW-1:0]       wr_ptr;
    logic                    wr_go;
    logic signed [OUT_W-1:0] wr_val;

    always_comb begin
        wr_go  = conv_vld && (!pool_en || phase);
        if (!pool_en)
            wr_val = conv_val;
        else
            wr_val = (conv_val > hold) ? conv_val : hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            hold      <= '0;
            wr_ptr    <= '0;
            res_we    <= 1'b0;
            res_addr  <= '0;
            res_wdata <= '0;
        end else begin
            res_we <= 1'b0;
            if (clear) begin
                phase  <= 1'b0;
                wr_ptr <= '0;
            end else if (conv_vld) begin
                if (pool_en && !phase) begin
                    // An unpaired last result of a kernel is dropped.
                    if (!conv_klast) begin
                        hold  <= conv_val;
                        phase <= 1'b1;
                    end
                end else begin
                    phase <= 1'b0;
                end
                if (wr_go) begin
                    res_we    <= 1'b1;
                    res_addr  <= wr_ptr;
                    res_wdata <= wr_val;
                    wr_ptr    <= wr_ptr + RES_AW'(1);
                end
            end
        end
    end

    // R4: a pooled write is never smaller than the first member of its pair
    assert_pool_pair_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && pool_en) |-> (res_wdata >= hold));
    // R5: a pair never straddles a kernel boundary
    assert_pair_in_kernel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_vld && conv_klast && pool_en) |=> !phase);
endmodule

// File: rtl/conv3n_engine.sv
module conv3n_engine
    import ce_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int MAX_N = 8,
    parameter int MAX_K = 4,
    localparam int W_W    = $clog2(MAX_W + 1),
    localparam int N_W    = $clog2(MAX_N + 1),
    localparam int K_W    = $clog2(MAX_K + 1),
    localparam int IMG_AW = $clog2(3 * MAX_W),
    localparam int KER_AW = $clog2(3 * MAX_N * MAX_K),
    localparam int RES_AW = $clog2(MAX_K * MAX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [W_W-1:0]    cfg_width,
    input  logic [N_W-1:0]    cfg_ncols,
    input  logic [K_W-1:0]    cfg_nkern,
    input  logic              cfg_pool,
    output logic              img_rd_en,
    output logic [IMG_AW-1:0] img_addr,
    input  logic [PIX_W-1:0]  img_rdata,
    output logic              ker_rd_en,
    output logic [KER_AW-1:0] ker_addr,
    input  logic [PIX_W-1:0]  ker_rdata,
    output logic              res_we,
    output logic [RES_AW-1:0] res_addr,
    output logic [OUT_W-1:0]  res_wdata,
    output logic              done
);
    ce_state_t state, state_nxt;

    logic [W_W-1:0] w_q;
    logic [N_W-1:0] n_q;
    logic [K_W-1:0] k_q;
    logic           pool_q;
    logic           accept, run, busy;

    logic iss_first, iss_last, iss_klast, iss_final;
    logic conv_vld, conv_klast, conv_final;
    logic signed [OUT_W-1:0] conv_val;
    logic signed [OUT_W-1:0] wdata_s;

    always_comb begin
        busy   = (state == ST_RUN) || (state == ST_DRAIN) || (state == ST_FLUSH);
        accept = start && !busy;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nxt = ST_RUN;
            ST_RUN:   if (iss_final) state_nxt = ST_DRAIN;
            ST_DRAIN: if (conv_vld && conv_final) state_nxt = ST_FLUSH;
            ST_FLUSH: state_nxt = ST_DONE;
            ST_DONE:  if (accept) state_nxt = ST_RUN;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            w_q    <= '0;
            n_q    <= '0;
            k_q    <= '0;
            pool_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                w_q    <= cfg_width;
                n_q    <= cfg_ncols;
                k_q    <= cfg_nkern;
                pool_q <= cfg_pool;
            end
        end
    end

    always_comb begin
        run       = (state == ST_RUN);
        img_rd_en = run;
        ker_rd_en = run;
        done      = (state == ST_DONE);
        res_wdata = wdata_s;
    end

    ce_agu #(.MAX_W(MAX_W), .MAX_N(MAX_N), .MAX_K(MAX_K)) u_agu (
        .clk(clk), .rst_n(rst_n), .clear(accept), .run(run),
        .w_q(w_q), .n_q(n_q), .k_q(k_q),
        .img_addr(img_addr), .ker_addr(ker_addr),
        .iss_first(iss_first), .iss_last(iss_last),
        .iss_klast(iss_klast), .iss_final(iss_final)
    );

    ce_mac u_mac (
        .clk(clk), .rst_n(rst_n), .iss_vld(run),
        .iss_first(iss_first), .iss_last(iss_last),
        .iss_klast(iss_klast), .iss_final(iss_final),
        .pix(img_rdata), .wt(ker_rdata),
        .conv_vld(conv_vld), .conv_val(conv_val),
        .conv_klast(conv_klast), .conv_final(conv_final)
    );

    ce_pool #(.RES_AW(RES_AW)) u_pool (
        .clk(clk), .rst_n(rst_n), .clear(accept), .pool_en(pool_q),
        .conv_vld(conv_vld), .conv_val(conv_val), .conv_klast(conv_klast),
        .res_we(res_we), .res_addr(res_addr), .res_wdata(wdata_s)
    );

    // R8: done holds until a start pulse
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R8: nothing is written once done is raised
    assert_no_write_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !res_we);
    // R9: a start while busy leaves the captured configuration untouched
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(w_q) && $stable(n_q) && $stable(k_q) && $stable(pool_q)));
    // R1: no reads outside a run
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!img_rd_en && !res_we));
endmodule

// File: tb/tb_conv3n_engine.sv
`timescale 1ns/1ps
module tb_conv3n_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cfg_width = '0;
    logic [3:0]  cfg_ncols = '0;
    logic [2:0]  cfg_nkern = '0;
    logic        cfg_pool = 1'b0;
    logic        img_rd_en, ker_rd_en, res_we, done;
    logic [6:0]  img_addr, ker_addr, res_addr;
    logic [7:0]  img_rdata, ker_rdata;
    logic [15:0] res_wdata;

    logic signed [7:0] img_mem [0:127];
    logic signed [7:0] ker_mem [0:127];

    int exp_addr[$];
    int exp_data[$];
    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R3";

    always #10 clk = ~clk;

    conv3n_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_ncols(cfg_ncols), .cfg_nkern(cfg_nkern), .cfg_pool(cfg_pool),
        .img_rd_en(img_rd_en), .img_addr(img_addr), .img_rdata(img_rdata),
        .ker_rd_en(ker_rd_en), .ker_addr(ker_addr), .ker_rdata(ker_rdata),
        .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata), .done(done)
    );

    always @(posedge clk) begin
        img_rdata <= img_mem[img_addr];
        ker_rdata <= ker_mem[ker_addr];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare every result write.
    always @(negedge clk) begin
        if (rst_n && res_we) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R7 unexpected write", int'(res_addr), -1);
            end else begin
                int ea, ed;
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                check(int'(res_addr) == ea, "R7 address", int'(res_addr), ea);
                check(int'($signed(res_wdata)) == ed, cur_tag, int'($signed(res_wdata)), ed);
            end
        end
    end

    function automatic int clamp16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Driver side: fill memories and queue the expected writes.
    task automatic prepare(input int w, input int n, input int k, input bit pool, input int mode);
        int cv[0:31];
        int cnt, per;
        for (int a = 0; a < 128; a++) begin
            case (mode)
                1: begin img_mem[a] = 8'sd127;  ker_mem[a] = 8'sd127;  end
                2: begin img_mem[a] = 8'sd127;  ker_mem[a] = -8'sd128; end
                default: begin
                    img_mem[a] = 8'($urandom_range(0, 255));
                    ker_mem[a] = 8'($urandom_range(0, 255));
                end
            endcase
        end
        cnt = w - n + 1;
        per = pool ? cnt / 2 : cnt;
        for (int kk = 0; kk < k; kk++) begin
            for (int i = 0; i < cnt; i++) begin
                int s;
                s = 0;
                for (int r = 0; r < 3; r++)
                    for (int j = 0; j < n; j++)
                        s += int'(img_mem[r*w + i + j]) * int'(ker_mem[kk*3*n + r*n + j]);
                cv[i] = clamp16(s);
            end
            for (int m = 0; m < per; m++) begin
                exp_addr.push_back(kk*per + m);
                if (pool)
                    exp_data.push_back(cv[2*m] > cv[2*m+1] ? cv[2*m] : cv[2*m+1]);
                else
                    exp_data.push_back(cv[m]);
            end
        end
    endtask

    task automatic run_case(input int w, input int n, input int k, input bit pool,
                            input int mode, input bit poke, input string tag);
        int waited;
        cur_tag = tag;
        prepare(w, n, k, pool, mode);
        @(negedge clk);
        cfg_width = 6'(w); cfg_ncols = 4'(n); cfg_nkern = 3'(k); cfg_pool = pool;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R8 done falls after start", int'(done), 0);
        // R10: scramble configuration during the run
        cfg_width = 6'd9; cfg_ncols = 4'd2; cfg_nkern = 3'd1; cfg_pool = ~pool;
        if (poke) begin
            repeat (15) @(negedge clk);
            start = 1'b1;   // R9: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R8 done reached", int'(done), 1);
        check(exp_addr.size() == 0, "R8 all writes before done", exp_addr.size(), 0);
        exp_addr.delete();
        exp_data.delete();
        repeat (3) @(negedge clk);
        check(done == 1'b1 && res_we == 1'b0, "R8 done holds without writes", int'(done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!done && !img_rd_en && !ker_rd_en && !res_we, "R1 reset idle",
              int'({done, img_rd_en, res_we}), 0);

        run_case(8, 3, 2, 1'b0, 0, 1'b0, "R6 R3 bypass");
        run_case(8, 3, 2, 1'b1, 0, 1'b0, "R4 pooled pairs");
        run_case(8, 2, 3, 1'b1, 0, 1'b0, "R5 odd count drop");
        run_case(6, 6, 1, 1'b0, 1, 1'b0, "R3 positive clamp N=W");
        run_case(5, 1, 4, 1'b0, 2, 1'b0, "R3 negative clamp N=1");
        run_case(32, 8, 4, 1'b1, 0, 1'b0, "R11 R2 widest strip pooled");
        run_case(4, 4, 2, 1'b1, 0, 1'b0, "R5 single result dropped");
        run_case(10, 3, 1, 1'b0, 0, 1'b1, "R9 R10 busy start");
        run_case(7, 2, 2, 1'b0, 0, 1'b0, "R2 R7 layout");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule